// File: doc/BRIEF.md
# SDRAM Write Auto-Precharge Bank Tracker

This block lives inside an SDRAM controller. It watches the command stream that the controller issues and follows every write burst as it runs. For each accepted write it marks the cycles that carry write data and numbers each beat. Write data starts in the cycle of the WRITE command itself, and the programmed CAS latency has no effect on that timing.

When a write is issued with the auto-precharge bit set, its bank is held busy. The hold lasts through the rest of the burst and then for a programmable data-in-to-active delay, counted in clock cycles. A command of any kind to a busy bank is flagged as an error in the same cycle, and the block acts as if the command had not been issued. A READ or WRITE that is accepted for another bank ends the current burst at once. If the burst it ends was an auto-precharge write, that bank's delay still runs from its last accepted beat.

Four banks are tracked, each with its own down-counter. The controller reads the per-bank busy vector and the error flag to decide what it may issue next.

Top module: `sdram_wap_tracker`

## Requirements
- R1: Command encoding on `cmd`: 00 NOP, 01 ACTIVE, 10 READ, 11 WRITE. An accepted WRITE raises `wrDataValid` in the same cycle, with `wrBeatIdx` = 0 and `wrBank` = the command's bank. Each later cycle carries the next beat until the burst is done. The burst length is taken from `cfgBurst4` when the WRITE is issued: 0 gives 2 beats and 1 gives 4 beats. Beat indices run from 0 up to length-1.
- R2: `cfgCasLat3` (0 = latency 2, 1 = latency 3) does not change the cycles or indices of write beats.
- R3: An accepted WRITE with `cmdA10` = 1 sets `bankBusy` for its bank from the next cycle onward. A WRITE with `cmdA10` = 0 never sets `bankBusy`.
- R4: After an auto-precharge burst completes with its last beat in cycle L, the bank stays busy through cycle L+`cfgDal`. It is free from cycle L+`cfgDal`+1. `cfgDal` must be at least 1.
- R5: A non-NOP command to a bank whose `bankBusy` bit is set raises `cmdError` in the same cycle and is ignored. A burst in progress keeps its beats.
- R6: An accepted READ or WRITE during a burst ends that burst. No further beats of it appear. An interrupting WRITE shows its own beat 0 in that same cycle, and an interrupting READ shows no beat.
- R7: An auto-precharge burst that is ended early still holds its bank busy until cycle L+`cfgDal`+1, where L is the cycle of its last accepted beat.
- R8: An ACTIVE to a bank that is not busy gives no error and leaves a running burst untouched.
- R9: While `rstN` is low at a clock edge, all bank timers, busy bits and any burst in progress are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmd | input | 2 | Command code (see R1) |
| cmdBank | input | 2 | Bank addressed by the command |
| cmdA10 | input | 1 | Auto-precharge select for WRITE |
| cfgBurst4 | input | 1 | Burst length select: 0 = 2 beats, 1 = 4 beats |
| cfgCasLat3 | input | 1 | CAS latency select (no effect on writes) |
| cfgDal | input | DAL_W | Data-in-to-active delay in cycles |
| wrDataValid | output | 1 | A write data beat is taken this cycle |
| wrBeatIdx | output | 2 | Index of the current beat |
| wrBank | output | 2 | Bank of the current beat |
| bankBusy | output | 4 | Per-bank busy flags |
| cmdError | output | 1 | Current command is illegal and ignored |

## Verification
The bench targets bursts that are ended by a WRITE or a READ to another bank. A design that let old beats leak through after the cut would show the wrong bank or index. A design that restarted the delay at the interrupt cycle, instead of at the last beat, would release the bank one cycle late. The bench probes the release cycle with ACTIVE commands one cycle before and in the exact release cycle, with delays of 1 and 3, so an off-by-one in the counter load is seen as a wrong error flag. It also checks that a command to a bank with a running auto-precharge burst is refused without disturbing the beats, and that changing the CAS latency leaves write timing as it was.

// File: rtl/sdram_wap_pkg.sv
package sdram_wap_pkg;

  parameter int NUM_BANKS = 4;
  localparam int BANK_W = $clog2(NUM_BANKS);
  parameter int MAX_BURST = 4;
  localparam int BEAT_W = $clog2(MAX_BURST);

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic              load;      // arm a bank countdown this edge
    logic [BANK_W-1:0] bank;      // which bank
    logic              shortLoad; // burst ended by interrupt: last beat was one cycle ago
  } tmrStrobe_t;

endpackage

// File: rtl/sdram_wap_ctrl.sv
module sdram_wap_ctrl
  import sdram_wap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cmd,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdA10,
  input  logic                 cfgBurst4,
  input  logic [NUM_BANKS-1:0] cntBusy,
  output tmrStrobe_t           strobe,
  output logic                 wrDataValid,
  output logic [BEAT_W-1:0]    wrBeatIdx,
  output logic [BANK_W-1:0]    wrBank,
  output logic [NUM_BANKS-1:0] bankBusy,
  output logic                 cmdError
);

  cmd_e cmdE;
  logic actQ;
  logic apQ;
  logic [BANK_W-1:0] bankQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] lastQ;

  logic [NUM_BANKS-1:0] apMask;
  logic cmdHit, cmdOk, wrStart, cutNow, contBeat, lastBeat;

  assign cmdE = cmd_e'(cmd);

  always_comb begin
    apMask = '0;
    if (actQ && apQ) apMask[bankQ] = 1'b1;
  end

  assign bankBusy = apMask | cntBusy;

  assign cmdHit   = (cmdE != CMD_NOP);
  assign cmdError = cmdHit && bankBusy[cmdBank];
  assign cmdOk    = cmdHit && !cmdError;
  assign wrStart  = cmdOk && (cmdE == CMD_WR);
  assign cutNow   = actQ && cmdOk && ((cmdE == CMD_WR) || (cmdE == CMD_RD));
  assign contBeat = actQ && !cutNow;
  assign lastBeat = contBeat && (beatQ == lastQ);

  assign wrDataValid = wrStart || contBeat;
  assign wrBeatIdx   = wrStart ? '0 : beatQ;
  assign wrBank      = wrStart ? cmdBank : bankQ;

  always_comb begin
    strobe.load      = actQ && apQ && (cutNow || lastBeat);
    strobe.bank      = bankQ;
    strobe.shortLoad = cutNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ  <= 1'b0;
      apQ   <= 1'b0;
      bankQ <= '0;
      beatQ <= '0;
      lastQ <= '0;
    end else if (wrStart) begin
      actQ  <= 1'b1;
      apQ   <= cmdA10;
      bankQ <= cmdBank;
      beatQ <= BEAT_W'(1);
      lastQ <= cfgBurst4 ? BEAT_W'(MAX_BURST - 1) : BEAT_W'(1);
    end else if (cutNow || lastBeat) begin
      actQ <= 1'b0;
      apQ  <= 1'b0;
    end else if (contBeat) begin
      beatQ <= beatQ + BEAT_W'(1);
    end
  end

endmodule

// File: rtl/sdram_wap_timers.sv
module sdram_wap_timers
  import sdram_wap_pkg::*;
#(
  parameter int DAL_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmrStrobe_t           strobe,
  input  logic [DAL_W-1:0]     cfgDal,
  output logic [NUM_BANKS-1:0] cntBusy
);

  logic [DAL_W-1:0] loadVal;

  // an interrupted burst had its last beat one cycle before the load edge
  assign loadVal = (strobe.shortLoad && (cfgDal != '0)) ? (cfgDal - DAL_W'(1)) : cfgDal;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DAL_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strobe.load && (strobe.bank == BANK_W'(b))) begin
        cntQ <= loadVal;
      end else if (cntQ != '0) begin
        cntQ <= cntQ - DAL_W'(1);
      end
    end

    assign cntBusy[b] = (cntQ != '0);
  end

endmodule

// File: rtl/sdram_wap_tracker.sv
module sdram_wap_tracker
  import sdram_wap_pkg::*;
#(
  parameter int DAL_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cmd,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdA10,
  input  logic                 cfgBurst4,
  input  logic                 cfgCasLat3,
  input  logic [DAL_W-1:0]     cfgDal,
  output logic                 wrDataValid,
  output logic [BEAT_W-1:0]    wrBeatIdx,
  output logic [BANK_W-1:0]    wrBank,
  output logic [NUM_BANKS-1:0] bankBusy,
  output logic                 cmdError
);

  tmrStrobe_t strobe;
  logic [NUM_BANKS-1:0] cntBusy;
  logic unusedCasLat;

  // write data follows the command edge regardless of CAS latency
  assign unusedCasLat = cfgCasLat3;

  sdram_wap_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .cmdBank    (cmdBank),
    .cmdA10     (cmdA10),
    .cfgBurst4  (cfgBurst4),
    .cntBusy    (cntBusy),
    .strobe     (strobe),
    .wrDataValid(wrDataValid),
    .wrBeatIdx  (wrBeatIdx),
    .wrBank     (wrBank),
    .bankBusy   (bankBusy),
    .cmdError   (cmdError)
  );

  sdram_wap_timers #(.DAL_W(DAL_W)) u_timers (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgDal (cfgDal),
    .cntBusy(cntBusy)
  );

endmodule

// File: rtl/sdram_wap_checker.sv
module sdram_wap_checker
  import sdram_wap_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           cmd,
  input logic [BANK_W-1:0]    cmdBank,
  input logic                 wrDataValid,
  input logic [BEAT_W-1:0]    wrBeatIdx,
  input logic [BANK_W-1:0]    wrBank,
  input logic [NUM_BANKS-1:0] bankBusy,
  input logic                 cmdError
);

  p_write_beat0_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'b11 && !cmdError) |-> (wrDataValid && wrBeatIdx == '0 && wrBank == cmdBank));

  p_beat_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrDataValid && wrBeatIdx != '0) |->
      ($past(wrDataValid) && wrBeatIdx == BEAT_W'($past(wrBeatIdx) + BEAT_W'(1))
       && wrBank == $past(wrBank)));

  p_busy_cmd_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 2'b00 && bankBusy[cmdBank]) |-> cmdError);

  p_read_cut_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'b10 && !cmdError) |-> !wrDataValid);

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (bankBusy == '0));

endmodule

bind sdram_wap_tracker sdram_wap_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cmd        (cmd),
  .cmdBank    (cmdBank),
  .wrDataValid(wrDataValid),
  .wrBeatIdx  (wrBeatIdx),
  .wrBank     (wrBank),
  .bankBusy   (bankBusy),
  .cmdError   (cmdError)
);

// File: tb/test_sdram_wap_tracker.sv
module test_sdram_wap_tracker;

  localparam int DAL_W = 6;
  localparam logic [1:0] NOP = 2'b00, ACT = 2'b01, RD = 2'b10, WR = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmd = NOP;
  logic [1:0] cmdBank = '0;
  logic cmdA10 = 1'b0;
  logic cfgBurst4 = 1'b0;
  logic cfgCasLat3 = 1'b0;
  logic [DAL_W-1:0] cfgDal = DAL_W'(3);
  logic wrDataValid;
  logic [1:0] wrBeatIdx;
  logic [1:0] wrBank;
  logic [3:0] bankBusy;
  logic cmdError;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct {
    bit    v;
    int    idx;
    int    bank;
    bit    err;
    string req;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  sdram_wap_tracker #(.DAL_W(DAL_W)) i_sdram_wap_tracker (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank), .cmdA10(cmdA10),
    .cfgBurst4(cfgBurst4), .cfgCasLat3(cfgCasLat3), .cfgDal(cfgDal),
    .wrDataValid(wrDataValid), .wrBeatIdx(wrBeatIdx), .wrBank(wrBank),
    .bankBusy(bankBusy), .cmdError(cmdError)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: one command per cycle, expected result pushed to the scoreboard
  task automatic step(input logic [1:0] c, input int b, input bit a10,
                      input bit ev, input int ei, input int eb, input bit ee, input string req);
    exp_t e;
    @(posedge clk); #1;
    cmd = c; cmdBank = 2'(b); cmdA10 = a10;
    e.v = ev; e.idx = ei; e.bank = eb; e.err = ee; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic busyIs(input int b, input bit expv, input string req);
    #3;
    chk(bankBusy[b] == expv, req, $sformatf("bankBusy[%0d]", b), int'(bankBusy[b]), int'(expv));
  endtask

  // monitor: compares each cycle's outputs against the queued expectation
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(wrDataValid == e.v, e.req, "wrDataValid", int'(wrDataValid), int'(e.v));
      if (e.v && wrDataValid) begin
        chk(int'(wrBeatIdx) == e.idx, e.req, "wrBeatIdx", int'(wrBeatIdx), e.idx);
        chk(int'(wrBank) == e.bank, e.req, "wrBank", int'(wrBank), e.bank);
      end
      chk(cmdError == e.err, e.req, "cmdError", int'(cmdError), int'(e.err));
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not end actual 1 expected 0");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(wrDataValid == 1'b0, "R9", "reset wrDataValid", int'(wrDataValid), 0);
    chk(bankBusy == 4'b0, "R9", "reset bankBusy", int'(bankBusy), 0);
    chk(cmdError == 1'b0, "R9", "reset cmdError", int'(cmdError), 0);

    // R1/R3: two-beat write without auto-precharge
    cfgBurst4 = 1'b0;
    step(WR, 0, 0, 1, 0, 0, 0, "R1");
    step(NOP, 0, 0, 1, 1, 0, 0, "R1");
    busyIs(0, 1'b0, "R3");
    step(NOP, 0, 0, 0, 0, 0, 0, "R1");

    // R3/R4/R5: four-beat auto-precharge write, natural end, cfgDal = 3
    cfgBurst4 = 1'b1; cfgDal = DAL_W'(3);
    step(WR, 1, 1, 1, 0, 1, 0, "R1");
    step(RD, 1, 0, 1, 1, 1, 1, "R5");
    busyIs(1, 1'b1, "R3");
    step(NOP, 0, 0, 1, 2, 1, 0, "R5");
    step(NOP, 0, 0, 1, 3, 1, 0, "R1");
    step(ACT, 1, 0, 0, 0, 0, 1, "R4");
    step(NOP, 0, 0, 0, 0, 0, 0, "R4");
    step(ACT, 1, 0, 0, 0, 0, 1, "R4");
    busyIs(1, 1'b1, "R4");
    step(ACT, 1, 0, 0, 0, 0, 0, "R4");
    busyIs(1, 1'b0, "R4");

    // R2: CAS latency 3 leaves beat timing unchanged
    cfgCasLat3 = 1'b1;
    step(WR, 2, 0, 1, 0, 2, 0, "R2");
    step(NOP, 0, 0, 1, 1, 2, 0, "R2");
    step(NOP, 0, 0, 1, 2, 2, 0, "R2");
    step(NOP, 0, 0, 1, 3, 2, 0, "R2");
    busyIs(2, 1'b0, "R3");
    step(NOP, 0, 0, 0, 0, 0, 0, "R2");
    cfgCasLat3 = 1'b0;

    // R6/R7/R8: auto-precharge burst on bank 0 cut by a write to bank 3
    step(WR, 0, 1, 1, 0, 0, 0, "R1");
    step(NOP, 0, 0, 1, 1, 0, 0, "R1");
    step(WR, 3, 0, 1, 0, 3, 0, "R6");
    step(NOP, 0, 0, 1, 1, 3, 0, "R6");
    step(ACT, 0, 0, 1, 2, 3, 1, "R7");
    busyIs(0, 1'b1, "R7");
    step(ACT, 0, 0, 1, 3, 3, 0, "R8");
    busyIs(0, 1'b0, "R7");
    step(NOP, 0, 0, 0, 0, 0, 0, "R6");

    // R6/R7: auto-precharge burst on bank 2 cut by a read to bank 1
    step(WR, 2, 1, 1, 0, 2, 0, "R1");
    step(NOP, 0, 0, 1, 1, 2, 0, "R1");
    step(RD, 1, 0, 0, 0, 0, 0, "R6");
    step(NOP, 0, 0, 0, 0, 0, 0, "R6");
    step(ACT, 2, 0, 0, 0, 0, 1, "R7");
    step(ACT, 2, 0, 0, 0, 0, 0, "R7");

    // R4: two-beat auto-precharge with the minimum delay of 1
    cfgBurst4 = 1'b0; cfgDal = DAL_W'(1);
    step(WR, 3, 1, 1, 0, 3, 0, "R1");
    step(NOP, 0, 0, 1, 1, 3, 0, "R1");
    step(ACT, 3, 0, 0, 0, 0, 1, "R4");
    step(ACT, 3, 0, 0, 0, 0, 0, "R4");

    // R9: reset in the middle of an auto-precharge burst
    cfgBurst4 = 1'b1; cfgDal = DAL_W'(5);
    step(WR, 1, 1, 1, 0, 1, 0, "R1");
    @(posedge clk); #1;
    cmd = NOP; rstN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    #3;
    chk(bankBusy == 4'b0, "R9", "bankBusy after reset", int'(bankBusy), 0);
    chk(wrDataValid == 1'b0, "R9", "wrDataValid after reset", int'(wrDataValid), 0);
    step(ACT, 1, 0, 0, 0, 0, 0, "R9");
    step(NOP, 0, 0, 0, 0, 0, 0, "R9");

    @(posedge clk);
    @(posedge clk);
    finish();
  end

endmodule